// File: doc/BRIEF.md
# Rotating Frame Address Generator for an LCD Pixel Fetcher

This block produces the display-memory byte address of every pixel an LCD controller reads while it scans a frame in raster order. Each pixel occupies one 16-bit halfword, so every pixel step is two bytes. A 3-bit orientation code selects one of five address walks: straight, mirrored left-right, mirrored top-bottom, mirrored both ways, or turned by 90 degrees. In the 90-degree walk the source image is read column by column.

Software sets the orientation code and a base address, then raises the run enable. The meaning of the base address depends on the orientation. For the straight and left-right mirrored walks it is the first pixel of the frame. For the other three walks it is the last pixel of the frame. For a 320x240 frame that last pixel sits at byte 153598.

The orientation and base are copied into shadow registers when run rises. While run stays high, a change on those inputs has no effect and sets a sticky error flag. The frame-start strobe reloads the walk. Each pixel-advance strobe releases one address, which appears one cycle later with a valid pulse. Only adders are used; there is no multiplier.

Top module: `lcd_rot_addr_gen`

## Requirements
- R1: After reset, addr_vld_o is 0, addr_o is 0 and cfg_err_o is 0.
- R2: With orientation code 000 (straight), output pixel k of the frame has address S+2k, where S is the captured base.
- R3: With code 001 (left-right mirror), output pixel (x,y) of a W-wide frame has address S+2(yW+W-1-x).
- R4: With code 010 (top-bottom mirror, S = last pixel), output pixel (x,y) has address S-2(yW+W-1-x).
- R5: With code 011 (both mirrors, S = last pixel), output pixel (x,y) has address S-2(yW+x).
- R6: With code 100 (90-degree, S = last pixel), each output line holds H pixels and a frame holds W lines. Pixel x of output line l has address S-2l-2Wx.
- R7: A pix_adv_i accepted at a clock edge places its address on addr_o with addr_vld_o high for exactly the following cycle.
- R8: After W*H accepted pixels, pix_adv_i gives no valid output until the next frame_start_i. A frame_start_i issued mid-frame restarts the walk at the first address. frame_start_i takes priority over a pix_adv_i in the same cycle.
- R9: The mode_i and start_addr_i values are captured on the rising edge of run_i. While run_i stays high, a change on either input is ignored and sets cfg_err_o, which stays set until reset.
- R10: Codes 101, 110 and 111 are reserved. They produce the straight walk of R2 and set cfg_err_o.
- R11: frame_start_i and pix_adv_i are honoured only when run_i has been high in both the current and the previous cycle. Dropping run_i ends the walk, and a new frame_start_i is then needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Run enable; its rising edge captures the configuration |
| frame_start_i | input | 1 | Reloads the walk at the first pixel |
| pix_adv_i | input | 1 | Requests the next pixel address |
| mode_i | input | 3 | Orientation code |
| start_addr_i | input | AW | Base byte address |
| addr_o | output | AW | Byte address of the current pixel |
| addr_vld_o | output | 1 | addr_o holds a new pixel address this cycle |
| cfg_err_o | output | 1 | Sticky flag for a reserved code or a configuration write while running |

## Verification
The even-address assertion assumes the base address is halfword aligned. Every base the stimulus drives is even. The shadow and valid assertions assume run_i is a level that is held for many cycles, which matches how the bench drives it. Frame strobes are applied only after run has been high for two cycles, except in the tests that deliberately violate this to check that the strobes are ignored. All other configuration changes are made with run low, apart from the one test that provokes the error flag.

// File: rtl/lcd_rot_pkg.sv
package lcd_rot_pkg;
  typedef enum logic [2:0] {
    MODE_NORM  = 3'd0,
    MODE_HFLIP = 3'd1,
    MODE_VFLIP = 3'd2,
    MODE_BOTH  = 3'd3,
    MODE_ROT   = 3'd4
  } scan_mode_e;

  function automatic logic mode_reserved(input logic [2:0] code);
    return code > 3'd4;
  endfunction
endpackage

// File: rtl/lcd_rot_cfg.sv
module lcd_rot_cfg
  import lcd_rot_pkg::*;
#(
  parameter int AW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [2:0]    mode_i,
  input  logic [AW-1:0] start_i,
  output logic          run_ok_o,
  output scan_mode_e    mode_o,
  output logic [AW-1:0] start_o,
  output logic          err_o
);
  logic          running_q;
  logic [2:0]    raw_q;
  scan_mode_e    mode_q;
  logic [AW-1:0] start_q;
  logic          err_q;
  logic          capture;
  logic          dirty;

  assign capture = run_i & ~running_q;
  assign dirty   = running_q & run_i & ((mode_i != raw_q) | (start_i != start_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
      raw_q     <= '0;
      mode_q    <= MODE_NORM;
      start_q   <= '0;
      err_q     <= 1'b0;
    end else begin
      running_q <= run_i;
      if (capture) begin
        raw_q   <= mode_i;
        start_q <= start_i;
        mode_q  <= mode_reserved(mode_i) ? MODE_NORM : scan_mode_e'(mode_i);
        if (mode_reserved(mode_i)) err_q <= 1'b1;
      end
      if (dirty) err_q <= 1'b1;
    end
  end

  assign run_ok_o = running_q & run_i;
  assign mode_o   = mode_q;
  assign start_o  = start_q;
  assign err_o    = err_q;

  AST_SHADOW_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_q && $past(running_q)) |-> ($stable(mode_q) && $stable(start_q))); // R9
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q); // R9
endmodule

// File: rtl/lcd_rot_scan.sv
module lcd_rot_scan #(
  parameter int W = 320,
  parameter int H = 240
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rot_i,
  input  logic kill_i,
  input  logic load_i,
  input  logic adv_i,
  output logic active_o,
  output logic eol_o
);
  localparam int MAXD = (W > H) ? W : H;
  localparam int CW   = (MAXD > 1) ? $clog2(MAXD) : 1;
  localparam logic [CW-1:0] W_LAST = CW'(W - 1);
  localparam logic [CW-1:0] H_LAST = CW'(H - 1);

  logic [CW-1:0] col_q, row_q;
  logic          active_q;
  logic [CW-1:0] col_last, row_last;
  logic          eof;

  assign col_last = rot_i ? H_LAST : W_LAST;
  assign row_last = rot_i ? W_LAST : H_LAST;
  assign eol_o    = (col_q == col_last);
  assign eof      = eol_o & (row_q == row_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q    <= '0;
      row_q    <= '0;
      active_q <= 1'b0;
    end else if (kill_i) begin
      active_q <= 1'b0;
    end else if (load_i) begin
      col_q    <= '0;
      row_q    <= '0;
      active_q <= 1'b1;
    end else if (adv_i && active_q) begin
      if (eol_o) begin
        col_q <= '0;
        if (eof) active_q <= 1'b0;
        else     row_q    <= row_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  assign active_o = active_q;

  AST_COL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (col_q <= col_last && row_q <= row_last)); // R8
  AST_FRAME_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && active_q && eof && !load_i && !kill_i) |=> !active_q); // R8
endmodule

// File: rtl/lcd_rot_walk.sv
module lcd_rot_walk
  import lcd_rot_pkg::*;
#(
  parameter int W  = 320,
  parameter int AW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          adv_i,
  input  logic          eol_i,
  input  scan_mode_e    mode_i,
  input  logic [AW-1:0] start_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] PIX   = AW'(2);
  localparam logic [AW-1:0] PITCH = AW'(2 * W);
  localparam logic [AW-1:0] EDGE  = AW'(2 * (W - 1));

  logic [AW-1:0] cur_q, base_q;
  logic [AW-1:0] init_a, pix_step, line_step, next_line;

  always_comb begin
    init_a    = start_i;
    pix_step  = PIX;
    line_step = PITCH;
    unique case (mode_i)
      MODE_HFLIP: begin init_a = start_i + EDGE; pix_step = -PIX;   line_step = PITCH;  end
      MODE_VFLIP: begin init_a = start_i - EDGE; pix_step = PIX;    line_step = -PITCH; end
      MODE_BOTH:  begin                          pix_step = -PIX;   line_step = -PITCH; end
      MODE_ROT:   begin                          pix_step = -PITCH; line_step = -PIX;   end
      default:    begin end
    endcase
  end

  assign next_line = base_q + line_step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      base_q <= '0;
    end else if (load_i) begin
      cur_q  <= init_a;
      base_q <= init_a;
    end else if (adv_i) begin
      if (eol_i) begin
        base_q <= next_line;
        cur_q  <= next_line;
      end else begin
        cur_q  <= cur_q + pix_step;
      end
    end
  end

  assign addr_o = cur_q;
endmodule

// File: rtl/lcd_rot_addr_gen.sv
module lcd_rot_addr_gen
  import lcd_rot_pkg::*;
#(
  parameter int W  = 320,
  parameter int H  = 240,
  parameter int AW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          frame_start_i,
  input  logic          pix_adv_i,
  input  logic [2:0]    mode_i,
  input  logic [AW-1:0] start_addr_i,
  output logic [AW-1:0] addr_o,
  output logic          addr_vld_o,
  output logic          cfg_err_o
);
  logic          run_ok, active, eol, load, accept;
  scan_mode_e    mode_s;
  logic [AW-1:0] start_s, cur_addr;

  lcd_rot_cfg #(.AW(AW)) u_cfg (
    .clk_i, .rst_ni, .run_i,
    .mode_i, .start_i(start_addr_i),
    .run_ok_o(run_ok), .mode_o(mode_s), .start_o(start_s), .err_o(cfg_err_o)
  );

  assign load   = run_ok & frame_start_i;
  assign accept = run_ok & active & pix_adv_i & ~frame_start_i;

  lcd_rot_scan #(.W(W), .H(H)) u_scan (
    .clk_i, .rst_ni,
    .rot_i(mode_s == MODE_ROT), .kill_i(~run_ok),
    .load_i(load), .adv_i(accept),
    .active_o(active), .eol_o(eol)
  );

  lcd_rot_walk #(.W(W), .AW(AW)) u_walk (
    .clk_i, .rst_ni,
    .load_i(load), .adv_i(accept), .eol_i(eol),
    .mode_i(mode_s), .start_i(start_s), .addr_o(cur_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o     <= '0;
      addr_vld_o <= 1'b0;
    end else begin
      addr_vld_o <= accept;
      if (accept) addr_o <= cur_addr;
    end
  end

  AST_VLD_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_vld_o |-> $past(run_i)); // R11
  AST_VLD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_vld_o && !$past(pix_adv_i)) |-> 1'b0); // R7
  AST_ADDR_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_vld_o |-> !addr_o[0]); // R2
endmodule

// File: tb/tb_lcd_rot_addr_gen.sv
`timescale 1ns/1ps
module tb_lcd_rot_addr_gen;
  localparam int W = 6, H = 4, AW = 16, NPIX = W * H;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_ni, run_i, frame_start_i, pix_adv_i, addr_vld_o, cfg_err_o;
  logic [2:0] mode_i;
  logic [AW-1:0] start_addr_i, addr_o;

  lcd_rot_addr_gen #(.W(W), .H(H), .AW(AW)) dut (
    .clk_i(clk), .rst_ni, .run_i, .frame_start_i, .pix_adv_i,
    .mode_i, .start_addr_i, .addr_o, .addr_vld_o, .cfg_err_o
  );

  typedef struct packed {
    logic [2:0]    mode;
    logic [AW-1:0] start;
    logic [7:0]    idx;
    logic [AW-1:0] exp;
  } vec_t;

  localparam vec_t VECS [18] = '{
    '{3'd0, 16'h0100, 8'd0,  16'h0100}, '{3'd0, 16'h0100, 8'd7,  16'h010E}, '{3'd0, 16'h0100, 8'd23, 16'h012E},
    '{3'd1, 16'h0100, 8'd0,  16'h010A}, '{3'd1, 16'h0100, 8'd7,  16'h0114}, '{3'd1, 16'h0100, 8'd23, 16'h0124},
    '{3'd2, 16'h0200, 8'd0,  16'h01F6}, '{3'd2, 16'h0200, 8'd23, 16'h01DC}, '{3'd2, 16'h0200, 8'd6,  16'h01EA},
    '{3'd3, 16'h0200, 8'd0,  16'h0200}, '{3'd3, 16'h0200, 8'd6,  16'h01F4}, '{3'd3, 16'h0200, 8'd23, 16'h01D2},
    '{3'd4, 16'h0200, 8'd1,  16'h01F4}, '{3'd4, 16'h0200, 8'd4,  16'h01FE}, '{3'd4, 16'h0200, 8'd23, 16'h01D2},
    '{3'd5, 16'h0100, 8'd7,  16'h010E}, '{3'd6, 16'h0100, 8'd0,  16'h0100}, '{3'd7, 16'h0100, 8'd23, 16'h012E}
  };

  int n_chk = 0, n_fail = 0;
  logic [AW-1:0] got [NPIX];
  int ngot;

  task automatic chk(input bit ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] m);
    case (m)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd0: return "R2";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [AW-1:0] model(input logic [2:0] m, input int s, input int k);
    int x, y;
    if (m == 3'd4) begin
      y = k / H; x = k % H;
      return AW'(s - 2 * y - 2 * W * x);
    end
    x = k % W; y = k / W;
    case (m)
      3'd1: return AW'(s + 2 * (y * W + W - 1 - x));
      3'd2: return AW'(s - 2 * (y * W + W - 1 - x));
      3'd3: return AW'(s - 2 * (y * W + x));
      default: return AW'(s + 2 * k);
    endcase
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; run_i = 1'b0; frame_start_i = 1'b0; pix_adv_i = 1'b0;
    mode_i = '0; start_addr_i = '0;
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
  endtask

  task automatic start_run(input logic [2:0] m, input logic [AW-1:0] s);
    run_i = 1'b0; mode_i = m; start_addr_i = s;
    tick();
    run_i = 1'b1;
    tick(); tick();
  endtask

  task automatic run_frame();
    frame_start_i = 1'b1;
    tick();
    frame_start_i = 1'b0;
    ngot = 0;
    pix_adv_i = 1'b1;
    for (int c = 0; c < NPIX + 3; c++) begin
      tick();
      if (addr_vld_o) begin
        if (ngot < NPIX) got[ngot] = addr_o;
        ngot++;
      end
    end
    pix_adv_i = 1'b0;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int nv;
    bit all_ok;
    do_reset();
    // R1 reset state
    chk(addr_vld_o == 1'b0, "R1 vld", AW'(addr_vld_o), '0);
    chk(addr_o == '0, "R1 addr", addr_o, '0);
    chk(cfg_err_o == 1'b0, "R1 err", AW'(cfg_err_o), '0);

    // table walk: R2..R6 and R10 orientations
    for (int i = 0; i < 18; i++) begin
      start_run(VECS[i].mode, VECS[i].start);
      run_frame();
      chk(got[VECS[i].idx] == VECS[i].exp, req_of(VECS[i].mode), got[VECS[i].idx], VECS[i].exp);
      if (i % 3 == 0) begin
        chk(ngot == NPIX, "R8 count", AW'(ngot), AW'(NPIX));
        all_ok = 1'b1;
        for (int k = 0; k < NPIX; k++)
          if (got[k] != model(VECS[i].mode, int'(VECS[i].start), k)) all_ok = 1'b0;
        chk(all_ok, req_of(VECS[i].mode), AW'(all_ok), AW'(1));
      end
    end

    // R7 single-pulse timing
    do_reset();
    start_run(3'd0, 16'h0040);
    frame_start_i = 1'b1; tick(); frame_start_i = 1'b0;
    pix_adv_i = 1'b1; tick(); pix_adv_i = 1'b0;
    chk(addr_vld_o && addr_o == 16'h0040, "R7 vld", addr_o, 16'h0040);
    tick();
    chk(addr_vld_o == 1'b0, "R7 one cycle", AW'(addr_vld_o), '0);

    // R8 mid-frame restart, frame_start wins over pix_adv
    pix_adv_i = 1'b1;
    repeat (4) tick();
    frame_start_i = 1'b1; tick(); frame_start_i = 1'b0;
    chk(addr_vld_o == 1'b0, "R8 restart priority", AW'(addr_vld_o), '0);
    tick();
    chk(addr_vld_o && addr_o == 16'h0040, "R8 restart addr", addr_o, 16'h0040);
    pix_adv_i = 1'b0; tick();

    // R11 strobes ignored while not running, walk ends when run drops
    run_i = 1'b0; tick();
    frame_start_i = 1'b1; tick(); frame_start_i = 1'b0;
    pix_adv_i = 1'b1; nv = 0;
    repeat (4) begin tick(); if (addr_vld_o) nv++; end
    chk(nv == 0, "R11 run low", AW'(nv), '0);
    run_i = 1'b1; nv = 0;
    repeat (4) begin tick(); if (addr_vld_o) nv++; end
    chk(nv == 0, "R11 walk ended", AW'(nv), '0);
    pix_adv_i = 1'b0; tick();

    // R9 writes while running ignored, error sticky
    do_reset();
    start_run(3'd1, 16'h0100);
    chk(cfg_err_o == 1'b0, "R9 no err", AW'(cfg_err_o), '0);
    mode_i = 3'd2; start_addr_i = 16'h0300;
    tick();
    chk(cfg_err_o == 1'b1, "R9 err set", AW'(cfg_err_o), AW'(1));
    run_frame();
    chk(got[0] == 16'h010A, "R9 old config", got[0], 16'h010A);
    run_i = 1'b0; tick(); tick();
    chk(cfg_err_o == 1'b1, "R9 sticky", AW'(cfg_err_o), AW'(1));

    // R10 reserved code flags error
    do_reset();
    start_run(3'd6, 16'h0100);
    chk(cfg_err_o == 1'b1, "R10 err", AW'(cfg_err_o), AW'(1));
    run_frame();
    chk(got[7] == 16'h010E, "R10 walk", got[7], 16'h010E);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule